// File: doc/BRIEF.md
# Byte-Lane Asynchronous RAM Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide asynchronous static-style memory with two byte lanes. Each cycle it samples a pair of chip selects (`sel_n` is active low, `sel` is active high), a write strobe, an output-drive strobe and two active-low byte enables. From these it decodes one of four modes: deselected, read, output disabled or write. Each lane has its own drive flag, so a bench on the pins can tell a driven byte from a floating one. A write does not land in the array while the strobes are still active. The model holds the latest address, data and lane mask while the write window is open, and it commits them once the window closes.

The word count is `2**AW`. With `AW = 17` the model is the full 131072 x 16 part. The default is smaller so that the model stays cheap to elaborate. Every output follows the pins that were sampled two rising edges earlier: one edge into the sampling register and one into the output register. Array contents are undefined after reset.

Top module: `bl_sram_model`

## Requirements
- R1: While reset is held and just after it is released, `lane_drv` is 2'b00 and `rdata` is all zero.
- R2: When `sel_n` = 1, or `sel` = 0, or both `hi_en_n` and `lo_en_n` are 1, both lanes are undriven (`lane_drv` = 2'b00) and `rdata` = 0. This holds whatever the other pins are.
- R3: When the chip is selected and the block reads (`wr_n` = 1, `drv_n` = 0), `lane_drv[0]` equals the inverse of `lo_en_n` and `lane_drv[1]` equals the inverse of `hi_en_n`. A driven lane carries the stored byte: `rdata[7:0]` is the low byte and `rdata[15:8]` is the high byte. An undriven lane reads as zero.
- R4: When the chip is selected with `wr_n` = 1 and `drv_n` = 1, both lanes are undriven.
- R5: When the chip is selected with `wr_n` = 0, both lanes are undriven for any value of `drv_n`.
- R6: A write stores only the lanes whose byte enable is 0. A lane that is not enabled keeps its earlier content.
- R7: The write window is open while `sel_n` = 0, `sel` = 1, `wr_n` = 0 and at least one byte enable is 0. The write is committed when the window closes. The window can close because `wr_n` rises, `sel_n` rises, `sel` falls, or both byte enables go high.
- R8: The committed address, data and lane mask are those of the last sampled cycle inside the window. Values from earlier cycles of the same window are not stored.
- R9: A read sampled in the cycle in which the window closes, at the same address, returns the newly committed bytes.
- R10: All `2**AW` addresses are distinct. The highest address and address 0 hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| drv_n | input | 1 | Active-low output-drive strobe |
| hi_en_n | input | 1 | Active-low enable for the upper byte lane |
| lo_en_n | input | 1 | Active-low enable for the lower byte lane |
| wdata | input | 2*LW | Write data, upper lane in the top LW bits |
| rdata | output | 2*LW | Read data, zero on undriven lanes |
| lane_drv | output | 2 | Per-lane drive flag, bit 1 upper, bit 0 lower |

## Verification
The bench closes write windows in each of the four possible ways: strobe rising, either chip select dropping, and both byte enables going high. A design that missed one of these would never commit that write, or would commit it at the wrong time, and the following read would return stale data. Two cases check the "last cycle wins" rule. In one, the window narrows from two lanes to one. In the other, the address moves inside one window. A model that latched the first cycle, or wrote every cycle, would leave the wrong bytes or corrupt the earlier address. A read placed exactly on the closing cycle catches a missing forward path, because such a design returns the old word. Drive checks with the output strobe held low during writes, together with each deselect condition, expose a lane that is driven when it should float.

// File: rtl/bl_sram_pkg.sv
package bl_sram_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        MD_DESEL  = 2'd0,
        MD_READ   = 2'd1,
        MD_OUTOFF = 2'd2,
        MD_WRITE  = 2'd3
    } mode_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic drv_n;
        logic hi_n;
        logic lo_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1,
                                    drv_n: 1'b1, hi_n: 1'b1, lo_n: 1'b1};

endpackage

// File: rtl/bl_sram_decode.sv
module bl_sram_decode
    import bl_sram_pkg::*;
(
    input  ctrl_t            ctrl,
    output mode_e            mode,
    output logic [LANES-1:0] lane_sel,
    output logic             win
);

    always_comb begin
        lane_sel = {~ctrl.hi_n, ~ctrl.lo_n};
        if (ctrl.sel_n || !ctrl.sel || (lane_sel == '0)) begin
            mode = MD_DESEL;
        end else if (!ctrl.wr_n) begin
            mode = MD_WRITE;
        end else if (!ctrl.drv_n) begin
            mode = MD_READ;
        end else begin
            mode = MD_OUTOFF;
        end
        win = (mode == MD_WRITE);
    end

endmodule

// File: rtl/bl_sram_wrtrack.sv
module bl_sram_wrtrack
    import bl_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    input  logic [LANES-1:0] mask,
    output logic             commit,
    output logic [AW-1:0]    c_addr,
    output logic [DW-1:0]    c_data,
    output logic [LANES-1:0] c_mask
);

    typedef struct packed {
        logic             open;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [LANES-1:0] mask;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (win) begin
            trk_d.open = 1'b1;
            trk_d.addr = addr;
            trk_d.data = data;
            trk_d.mask = mask;
        end else begin
            trk_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign commit = trk_q.open && !win;
    assign c_addr = trk_q.addr;
    assign c_data = trk_q.data;
    assign c_mask = trk_q.mask;

endmodule

// File: rtl/bl_sram_array.sv
module bl_sram_array
    import bl_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [LANES-1:0]   wmask,
    input  logic [AW-1:0]      raddr,
    output logic [LANES*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) begin
                store[waddr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = store[raddr];
    end

endmodule

// File: rtl/bl_sram_model.sv
module bl_sram_model
    import bl_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                sel_n,
    input  logic                sel,
    input  logic                wr_n,
    input  logic                drv_n,
    input  logic                hi_en_n,
    input  logic                lo_en_n,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic [LANES-1:0]    lane_drv
);

    localparam int DW = LANES * LW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        ctrl_t         ctrl;
    } smp_t;

    typedef struct packed {
        logic [LANES-1:0] drv;
        logic [DW-1:0]    dat;
    } out_t;

    typedef struct packed {
        smp_t smp;
        out_t out;
    } st_t;

    st_t st_d, st_q;

    ctrl_t            ctrl_in;
    mode_e            mode;
    logic [LANES-1:0] lane_sel;
    logic             win;
    logic             commit;
    logic [AW-1:0]    c_addr;
    logic [DW-1:0]    c_data;
    logic [LANES-1:0] c_mask;
    logic [DW-1:0]    arr_rdata;
    logic [DW-1:0]    fwd;

    assign ctrl_in = {sel_n, sel, wr_n, drv_n, hi_en_n, lo_en_n};

    bl_sram_decode u_decode (
        .ctrl     (st_q.smp.ctrl),
        .mode     (mode),
        .lane_sel (lane_sel),
        .win      (win)
    );

    bl_sram_wrtrack #(.AW(AW), .DW(DW)) u_wrtrack (
        .clk    (clk),
        .rst_n  (rst_n),
        .win    (win),
        .addr   (st_q.smp.addr),
        .data   (st_q.smp.data),
        .mask   (lane_sel),
        .commit (commit),
        .c_addr (c_addr),
        .c_data (c_data),
        .c_mask (c_mask)
    );

    bl_sram_array #(.AW(AW), .LW(LW)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (c_addr),
        .wdata (c_data),
        .wmask (c_mask),
        .raddr (st_q.smp.addr),
        .rdata (arr_rdata)
    );

    always_comb begin
        st_d = st_q;
        st_d.smp.addr = addr;
        st_d.smp.data = wdata;
        st_d.smp.ctrl = ctrl_in;

        // bytes being committed this cycle bypass the array
        fwd = arr_rdata;
        for (int g = 0; g < LANES; g++) begin
            if (commit && (c_addr == st_q.smp.addr) && c_mask[g]) begin
                fwd[g*LW +: LW] = c_data[g*LW +: LW];
            end
        end

        st_d.out.drv = (mode == MD_READ) ? lane_sel : '0;
        for (int g = 0; g < LANES; g++) begin
            st_d.out.dat[g*LW +: LW] = st_d.out.drv[g] ? fwd[g*LW +: LW] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.smp.addr <= '0;
            st_q.smp.data <= '0;
            st_q.smp.ctrl <= CTRL_IDLE;
            st_q.out      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.out.dat;
    assign lane_drv = st_q.out.drv;

endmodule

// File: rtl/bl_sram_chk.sv
module bl_sram_chk
    import bl_sram_pkg::*;
#(
    parameter int LW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input mode_e               mode,
    input ctrl_t               ctrl_q,
    input logic                win,
    input logic                commit,
    input logic [LANES-1:0]    lane_drv,
    input logic [LANES*LW-1:0] rdata
);

    // R2
    desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_DESEL) |=> (lane_drv == '0) && (rdata == '0));

    // R4
    outoff_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OUTOFF) |=> (lane_drv == '0));

    // R5
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WRITE) |=> (lane_drv == '0));

    // R3
    read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ) |=> (lane_drv == ~{$past(ctrl_q.hi_n), $past(ctrl_q.lo_n)}));

    // R3
    lo_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drv[0] |-> (rdata[LW-1:0] == '0));

    // R3
    hi_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drv[1] |-> (rdata[2*LW-1:LW] == '0));

    // R7
    commit_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win) |-> commit);

    // R7
    commit_only_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!win && $past(win)));

endmodule

bind bl_sram_model bl_sram_chk #(.LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .ctrl_q   (st_q.smp.ctrl),
    .win      (win),
    .commit   (commit),
    .lane_drv (lane_drv),
    .rdata    (rdata)
);

// File: tb/bl_sram_model_tb.sv
module bl_sram_model_tb;

    localparam int AW = 10;

    typedef struct {
        int          due;
        logic [1:0]  drv;
        logic [15:0] dat;
        logic [1:0]  dchk;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, drv_n = 1'b1;
    logic          hi_en_n = 1'b1, lo_en_n = 1'b1;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    lane_drv;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    item_t       sbq[$];
    logic [15:0] shadow [int];
    logic [1:0]  known  [int];

    bit          p_open = 0;
    int          p_addr = 0;
    logic [15:0] p_data = '0;
    logic [1:0]  p_mask = '0;

    bl_sram_model #(.AW(AW), .LW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
        .wr_n(wr_n), .drv_n(drv_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t e;
            bit    wrong;
            e = sbq.pop_front();
            wrong = (lane_drv !== e.drv);
            for (int g = 0; g < 2; g++) begin
                if ((!e.drv[g] || e.dchk[g]) && (rdata[g*8 +: 8] !== (e.drv[g] ? e.dat[g*8 +: 8] : 8'h00)))
                    wrong = 1;
            end
            total++;
            if (wrong) begin
                bad++;
                $display("FAIL %s: lane_drv=%b rdata=%h expected lane_drv=%b rdata=%h (lane check %b)",
                         e.tag, lane_drv, rdata, e.drv, e.dat, e.dchk);
            end
        end
    end

    task automatic step(input logic sn, input logic s, input logic wn, input logic dn,
                        input logic hn, input logic ln, input int a, input logic [15:0] d,
                        input string tag);
        item_t      it;
        logic [1:0] ls;
        bit         w;
        @(negedge clk);
        sel_n = sn; sel = s; wr_n = wn; drv_n = dn; hi_en_n = hn; lo_en_n = ln;
        addr = AW'(a); wdata = d;
        ls = {~hn, ~ln};
        w = !sn && s && !wn && (ls != 2'b00);
        if (w) begin
            p_open = 1; p_addr = a; p_data = d; p_mask = ls;
        end else if (p_open) begin
            if (!shadow.exists(p_addr)) begin
                shadow[p_addr] = '0;
                known[p_addr]  = 2'b00;
            end
            for (int g = 0; g < 2; g++) begin
                if (p_mask[g]) begin
                    shadow[p_addr][g*8 +: 8] = p_data[g*8 +: 8];
                    known[p_addr][g] = 1'b1;
                end
            end
            p_open = 0;
        end
        it.due  = cyc + 2;
        it.tag  = tag;
        it.drv  = (!sn && s && (ls != 2'b00) && wn && !dn) ? ls : 2'b00;
        it.dat  = shadow.exists(a) ? shadow[a] : 16'h0000;
        it.dchk = known.exists(a) ? known[a] : 2'b00;
        sbq.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(1, 0, 1, 1, 1, 1, 0, 16'h0000, tag);
    endtask

    task automatic rd(input int a, input logic hn, input logic ln, input string tag);
        step(0, 1, 1, 0, hn, ln, a, 16'h0000, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        total++;
        if (lane_drv !== 2'b00 || rdata !== 16'h0000) begin
            bad++;
            $display("FAIL R1: lane_drv=%b rdata=%h expected 00 0000", lane_drv, rdata);
        end
        idle("R1");
        idle("R1");

        // full write, closed by strobe rising into a read of the same word (R9)
        step(0, 1, 0, 1, 0, 0, 5, 16'hA1B2, "R5");
        step(0, 1, 0, 1, 0, 0, 5, 16'hA1B2, "R5");
        rd(5, 0, 0, "R9");
        rd(5, 0, 0, "R3");
        rd(5, 1, 0, "R3");
        rd(5, 0, 1, "R3");

        // deselect and output-disabled conditions
        step(1, 1, 1, 0, 0, 0, 5, 16'h0000, "R2");
        step(0, 0, 1, 0, 0, 0, 5, 16'h0000, "R2");
        step(0, 1, 1, 0, 1, 1, 5, 16'h0000, "R2");
        step(0, 1, 1, 1, 0, 0, 5, 16'h0000, "R4");

        // upper lane only, output strobe low, closed by sel_n rising (R6, R7)
        step(0, 1, 0, 0, 0, 1, 5, 16'h5599, "R5");
        step(0, 1, 0, 0, 0, 1, 5, 16'h5599, "R5");
        step(1, 1, 0, 0, 0, 1, 5, 16'h5599, "R7");
        rd(5, 0, 0, "R6");

        // lower lane only, closed by sel falling
        step(0, 1, 0, 1, 1, 0, 9, 16'h77C3, "R5");
        step(0, 1, 0, 1, 1, 0, 9, 16'h77C3, "R5");
        step(0, 0, 0, 1, 1, 0, 9, 16'h77C3, "R7");
        rd(9, 0, 0, "R6");

        // full word, closed by both byte enables going high
        step(0, 1, 0, 1, 0, 0, 9, 16'h1234, "R5");
        step(0, 1, 0, 1, 0, 0, 9, 16'h1234, "R5");
        step(0, 1, 0, 1, 1, 1, 9, 16'h1234, "R7");
        rd(9, 0, 0, "R7");

        // window narrows: upper enable drops first, last mask wins
        step(0, 1, 0, 1, 0, 0, 12, 16'hAAAA, "R5");
        step(0, 1, 1, 1, 0, 0, 12, 16'h0000, "R4");
        step(0, 1, 0, 1, 0, 0, 12, 16'hBBCC, "R5");
        step(0, 1, 0, 1, 1, 0, 12, 16'hBBCC, "R5");
        rd(12, 0, 0, "R8");

        // address moves inside one window: only the last address is stored
        step(0, 1, 0, 1, 0, 0, 20, 16'h0F0F, "R5");
        idle("R2");
        step(0, 1, 0, 1, 0, 0, 20, 16'h1111, "R5");
        step(0, 1, 0, 1, 0, 0, 21, 16'h2222, "R5");
        rd(21, 0, 0, "R8");
        rd(20, 0, 0, "R8");

        // top address and address zero are independent
        step(0, 1, 0, 1, 0, 0, (1 << AW) - 1, 16'hDEAD, "R5");
        idle("R2");
        step(0, 1, 0, 1, 0, 0, 0, 16'hBEEF, "R5");
        idle("R2");
        rd((1 << AW) - 1, 0, 0, "R10");
        rd(0, 0, 0, "R10");
        rd((1 << AW) - 1, 1, 0, "R10");

        repeat (4) idle("R2");
        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R3: %0d expectations unchecked, expected 0", sbq.size());
        end
        finish_run();
    end

endmodule